// File: doc/BRIEF.md
# Multi-Thread Co-Issue Arbiter

This block decides, every clock cycle, which hardware threads of a seven-thread execution unit may send their next instruction to the four functional units: two SIMD floating-point pipes, one branch pipe and one message-send pipe. Each thread offers a ready flag and a two-bit class code that names the pipe type its next instruction needs. Each pipe offers a busy flag. The arbiter hands out at most one instruction per pipe and at most one per thread. Up to four threads can therefore issue together.

Fairness is kept by a separate rotating priority pointer for each instruction class. After a grant, a class pointer moves to the thread just after the last thread granted in that class. A thread that is ready and waiting for a pipe is therefore reached within a bounded number of cycles. Floating-point requests may go to either FPU pipe, so two threads that never stall can keep both pipes fed. All grant outputs are registered.

Top module: `eu_coissue_arb`

## Requirements
- R1: A synchronous active-high reset clears every grant-valid bit and every granted thread ID to 0, and sets all three class priority pointers to thread 0.
- R2: A thread whose ready flag is low receives no grant.
- R3: A pipe whose busy flag is high receives no grant. Busy bit 0 is FPU pipe 0, bit 1 is FPU pipe 1, bit 2 is the branch pipe and bit 3 is the send pipe. A busy branch or send pipe does not block grants to the FPU pipes.
- R4: The class code of thread t sits in bits [2t+1:2t]. Code 0 requests an FPU pipe, 1 the branch pipe and 2 the send pipe. Code 3 requests nothing. A grant on a pipe only goes to a thread whose class matches that pipe.
- R5: In one cycle, no thread receives more than one grant. With all pipes free and requests present for every class, all four pipes are granted in the same cycle.
- R6: With both FPU pipes free, the highest-priority FPU requester goes to pipe 0 and the next one to pipe 1. With exactly one FPU pipe free, the highest-priority FPU requester goes to that pipe.
- R7: Each class scans threads starting at its own pointer, in increasing thread order, wrapping from 6 to 0. After a grant in that class, the pointer becomes one past the last thread granted in it. So a class with more requesters than pipes serves them in rotation.
- R8: Grants appear on the outputs one clock after the inputs that caused them. A pipe without a grant shows valid 0 and thread ID 0. A cycle with no requests produces no valid grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | 7 | Per-thread ready flag |
| thr_class | input | 14 | Per-thread class code, 2 bits per thread |
| unit_busy | input | 4 | Per-pipe busy flag: FPU0, FPU1, branch, send |
| gnt_valid | output | 4 | Per-pipe grant valid, same bit order as unit_busy |
| gnt_tid | output | 12 | Granted thread ID, 3 bits per pipe, pipe 0 in bits [2:0] |

## Verification
The only internal state is the three class pointers. A wrong pointer does not corrupt the current grant; it changes which thread wins the next contended cycle in that class. The error therefore shows at the ports one cycle after the first contention that follows. The stimulus sweeps all seven threads through the FPU class, so each pointer value is observed. It also mixes the three classes, so a pointer moved by the wrong class shows up within a cycle or two. Reset in the middle of a run is checked by the first grant that follows it.

// File: rtl/eu_arb_pkg.sv
package eu_arb_pkg;
  typedef enum logic [1:0] {
    CLS_FPU  = 2'd0,
    CLS_BR   = 2'd1,
    CLS_SEND = 2'd2,
    CLS_NONE = 2'd3
  } fu_class_e;

  localparam int NUM_UNITS = 4;  // fpu0, fpu1, branch, send
  localparam int NUM_CLS   = 3;  // fpu, branch, send
  localparam int U_FPU0    = 0;
  localparam int U_FPU1    = 1;
  localparam int U_BR      = 2;
  localparam int U_SEND    = 3;
endpackage

// File: rtl/eu_req_mask.sv
module eu_req_mask
  import eu_arb_pkg::*;
#(
  parameter int NUM_THR = 7
) (
  input  logic [NUM_THR-1:0]                 thr_ready,
  input  logic [NUM_THR-1:0][1:0]            thr_class,
  input  logic [NUM_UNITS-1:0]               unit_busy,
  output logic [NUM_CLS-1:0][NUM_THR-1:0]    cls_req
);
  logic fpu_open;
  assign fpu_open = !(unit_busy[U_FPU0] && unit_busy[U_FPU1]);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign cls_req[0][t] = thr_ready[t] && (thr_class[t] == CLS_FPU)  && fpu_open;
    assign cls_req[1][t] = thr_ready[t] && (thr_class[t] == CLS_BR)   && !unit_busy[U_BR];
    assign cls_req[2][t] = thr_ready[t] && (thr_class[t] == CLS_SEND) && !unit_busy[U_SEND];
  end
endmodule

// File: rtl/eu_rr_pick.sv
module eu_rr_pick #(
  parameter int NUM_THR = 7,
  localparam int TW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic [NUM_THR-1:0] req,
  input  logic [TW-1:0]      ptr,
  output logic               vld,
  output logic [TW-1:0]      id
);
  always_comb begin
    vld = 1'b0;
    id  = '0;
    for (int i = NUM_THR - 1; i >= 0; i--) begin
      int idx;
      idx = int'(ptr) + i;
      if (idx >= NUM_THR) idx = idx - NUM_THR;
      if (req[idx]) begin
        vld = 1'b1;
        id  = TW'(idx);
      end
    end
  end
endmodule

// File: rtl/eu_coissue_arb.sv
module eu_coissue_arb
  import eu_arb_pkg::*;
#(
  parameter int NUM_THR = 7,
  localparam int TW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_THR-1:0]        thr_ready,
  input  logic [2*NUM_THR-1:0]      thr_class,
  input  logic [NUM_UNITS-1:0]      unit_busy,
  output logic [NUM_UNITS-1:0]      gnt_valid,
  output logic [NUM_UNITS*TW-1:0]   gnt_tid
);
  logic [NUM_THR-1:0][1:0]         cls_vec;
  logic [NUM_CLS-1:0][NUM_THR-1:0] cls_req;
  logic [NUM_CLS-1:0][TW-1:0]      ptr_q, ptr_d;
  logic [NUM_CLS-1:0]              pick_vld;
  logic [NUM_CLS-1:0][TW-1:0]      pick_id;
  logic [NUM_THR-1:0]              fpu_req2;
  logic                            f2_vld;
  logic [TW-1:0]                   f2_id;
  logic [NUM_UNITS-1:0]            gv_d, gv_q;
  logic [NUM_UNITS-1:0][TW-1:0]    gt_d, gt_q;

  assign cls_vec = thr_class;

  function automatic logic [TW-1:0] next_tid(input logic [TW-1:0] t);
    return (int'(t) == NUM_THR - 1) ? '0 : TW'(int'(t) + 1);
  endfunction

  eu_req_mask #(.NUM_THR(NUM_THR)) u_mask (
    .thr_ready (thr_ready),
    .thr_class (cls_vec),
    .unit_busy (unit_busy),
    .cls_req   (cls_req)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    eu_rr_pick #(.NUM_THR(NUM_THR)) u_pick (
      .req (cls_req[c]),
      .ptr (ptr_q[c]),
      .vld (pick_vld[c]),
      .id  (pick_id[c])
    );
  end

  // second FPU candidate: same scan with the first winner removed
  assign fpu_req2 = cls_req[0] & ~(NUM_THR'(pick_vld[0]) << pick_id[0]);

  eu_rr_pick #(.NUM_THR(NUM_THR)) u_pick_fpu2 (
    .req (fpu_req2),
    .ptr (ptr_q[0]),
    .vld (f2_vld),
    .id  (f2_id)
  );

  always_comb begin
    gv_d  = '0;
    gt_d  = '0;
    ptr_d = ptr_q;
    if (pick_vld[0]) begin
      if (!unit_busy[U_FPU0] && !unit_busy[U_FPU1]) begin
        gv_d[U_FPU0] = 1'b1;
        gt_d[U_FPU0] = pick_id[0];
        if (f2_vld) begin
          gv_d[U_FPU1] = 1'b1;
          gt_d[U_FPU1] = f2_id;
          ptr_d[0]     = next_tid(f2_id);
        end else begin
          ptr_d[0] = next_tid(pick_id[0]);
        end
      end else if (!unit_busy[U_FPU0]) begin
        gv_d[U_FPU0] = 1'b1;
        gt_d[U_FPU0] = pick_id[0];
        ptr_d[0]     = next_tid(pick_id[0]);
      end else begin
        gv_d[U_FPU1] = 1'b1;
        gt_d[U_FPU1] = pick_id[0];
        ptr_d[0]     = next_tid(pick_id[0]);
      end
    end
    if (pick_vld[1]) begin
      gv_d[U_BR] = 1'b1;
      gt_d[U_BR] = pick_id[1];
      ptr_d[1]   = next_tid(pick_id[1]);
    end
    if (pick_vld[2]) begin
      gv_d[U_SEND] = 1'b1;
      gt_d[U_SEND] = pick_id[2];
      ptr_d[2]     = next_tid(pick_id[2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gv_q  <= '0;
      gt_q  <= '0;
      ptr_q <= '0;
    end else begin
      gv_q  <= gv_d;
      gt_q  <= gt_d;
      ptr_q <= ptr_d;
    end
  end

  assign gnt_valid = gv_q;
  assign gnt_tid   = gt_q;

  // ---------------- assertions ----------------
  logic [NUM_THR-1:0]       ready_p;
  logic [NUM_THR-1:0][1:0]  cls_p;
  logic [NUM_UNITS-1:0]     busy_p;

  always_ff @(posedge clk) begin
    ready_p <= thr_ready;
    cls_p   <= cls_vec;
    busy_p  <= unit_busy;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    localparam logic [1:0] UCLS = (u < 2) ? 2'd0 : 2'(u - 1);

    p_ready_r2: assert property (@(posedge clk) disable iff (rst)
      gnt_valid[u] |-> ready_p[gt_q[u]]);

    p_busy_r3: assert property (@(posedge clk) disable iff (rst)
      busy_p[u] |-> !gnt_valid[u]);

    p_class_r4: assert property (@(posedge clk) disable iff (rst)
      gnt_valid[u] |-> (cls_p[gt_q[u]] == UCLS));

    p_tid_zero_r8: assert property (@(posedge clk) disable iff (rst)
      !gnt_valid[u] |-> (gt_q[u] == '0));

    for (genvar v = u + 1; v < NUM_UNITS; v++) begin : g_pair
      p_distinct_r5: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid[u] && gnt_valid[v]) |-> (gt_q[u] != gt_q[v]));
    end
  end

  p_fpu_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid[U_FPU1] && !busy_p[U_FPU0]) |-> gnt_valid[U_FPU0]);

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (ready_p == '0) |-> (gnt_valid == '0));
endmodule

// File: tb/test_eu_coissue_arb.sv
module test_eu_coissue_arb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  thr_ready = '0;
  logic [13:0] thr_class = '0;
  logic [3:0]  unit_busy = '0;
  logic [3:0]  gnt_valid;
  logic [11:0] gnt_tid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  eu_coissue_arb i_eu_coissue_arb (
    .clk       (clk),
    .rst       (rst),
    .thr_ready (thr_ready),
    .thr_class (thr_class),
    .unit_busy (unit_busy),
    .gnt_valid (gnt_valid),
    .gnt_tid   (gnt_tid)
  );

  // entry: {req no, ready, class, busy, exp valid, exp tid {send,br,fpu1,fpu0}}
  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {4'd8, 7'h00, 14'h0000, 4'h0, 4'b0000, {3'd0,3'd0,3'd0,3'd0}}, // R8 idle
    {4'd6, 7'h7F, 14'h0000, 4'h0, 4'b0011, {3'd0,3'd0,3'd1,3'd0}}, // R6 fpu0 then fpu1
    {4'd7, 7'h7F, 14'h0000, 4'h0, 4'b0011, {3'd0,3'd0,3'd3,3'd2}}, // R7 rotate
    {4'd7, 7'h7F, 14'h0000, 4'h0, 4'b0011, {3'd0,3'd0,3'd5,3'd4}}, // R7 rotate
    {4'd7, 7'h7F, 14'h0000, 4'h0, 4'b0011, {3'd0,3'd0,3'd0,3'd6}}, // R7 wrap
    {4'd5, 7'h7F, 14'h0909, 4'h0, 4'b1111, {3'd1,3'd0,3'd3,3'd2}}, // R5 four distinct
    {4'd7, 7'h7F, 14'h0909, 4'h0, 4'b1111, {3'd5,3'd4,3'd2,3'd6}}, // R7 per class
    {4'd6, 7'h7F, 14'h0909, 4'h1, 4'b1110, {3'd1,3'd0,3'd3,3'd0}}, // R6 fpu0 busy
    {4'd3, 7'h50, 14'h0909, 4'hC, 4'b0001, {3'd0,3'd0,3'd0,3'd6}}, // R3 br/send busy
    {4'd4, 7'h7F, 14'h3FFF, 4'h0, 4'b0000, {3'd0,3'd0,3'd0,3'd0}}, // R4 code 3
    {4'd2, 7'h0A, 14'h0909, 4'h0, 4'b1001, {3'd1,3'd0,3'd0,3'd3}}, // R2 ready mask
    {4'd3, 7'h7F, 14'h0909, 4'h3, 4'b1100, {3'd5,3'd4,3'd0,3'd0}}  // R3 fpus busy
  };

  task automatic check(input string req, input logic [3:0] ev, input logic [11:0] et);
    checks++;
    if (gnt_valid !== ev || gnt_tid !== et) begin
      errors++;
      $display("FAIL %s valid=%b tid=%h expected valid=%b tid=%h",
               req, gnt_valid, gnt_tid, ev, et);
    end
  endtask

  task automatic drive(input logic [6:0] r, input logic [13:0] c, input logic [3:0] b);
    thr_ready = r;
    thr_class = c;
    unit_busy = b;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 4'b0000, 12'h000);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][40:34], VEC[k][33:20], VEC[k][19:16]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[k][44:41], k), VEC[k][15:12], VEC[k][11:0]);
    end

    // R1: reset in mid-run clears outputs and pointers
    drive(7'h7F, 14'h0000, 4'h0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 4'b0000, 12'h000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 R7 pointer back at thread 0", 4'b0011, {3'd0,3'd0,3'd1,3'd0});

    // R7: three FPU threads share one free pipe in rotation; R6 single free pipe
    drive(7'h07, 14'h0000, 4'h2);
    @(negedge clk);
    check("R7 rotation t2", 4'b0001, {3'd0,3'd0,3'd0,3'd2});
    @(negedge clk);
    check("R7 rotation t0", 4'b0001, {3'd0,3'd0,3'd0,3'd0});
    @(negedge clk);
    check("R7 rotation t1", 4'b0001, {3'd0,3'd0,3'd0,3'd1});
    @(negedge clk);
    check("R7 rotation t2 again", 4'b0001, {3'd0,3'd0,3'd0,3'd2});

    // R6: only fpu1 free, first requester lands on fpu1
    drive(7'h07, 14'h0000, 4'h1);
    @(negedge clk);
    check("R6 lone fpu1", 4'b0010, {3'd0,3'd0,3'd0,3'd0});

    // R8: idle after activity
    drive(7'h00, 14'h0000, 4'h0);
    @(negedge clk);
    check("R8 idle after activity", 4'b0000, 12'h000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule